// File: doc/BRIEF.md
# Direct-Page Word Increment and Decrement Unit

This unit adds one to, or subtracts one from, a 16-bit little-endian word kept in two neighbouring bytes of a 256-byte direct page. It has only an 8-bit memory port. A controller starts it with a one-cycle `start` pulse and an opcode. The unit then takes the page offset from the instruction stream through a one-byte fetch port. It handles the low byte first: read, adjust, write back. Only after that does it read the high byte, merge in any carry or borrow, and write it back.

A 16-bit internal accumulator carries the carry or borrow. Loading the low byte into it already applies the plus or minus one. Adding the high byte shifted up by eight then completes the word. The sign and zero flags are set from the whole 16-bit result when the last write finishes. Memory reads are combinational: `mem_rdata` must be valid in the same cycle as `mem_rd`, and the same holds for `pc_byte` during `pc_req`.

Top module: `dpw_word_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `pc_req`, `mem_rd`, `mem_wr`, `flag_n` and `flag_z` are all 0.
- R2: Opcode 0x3A adds one to the word {byte[off+1], byte[off]}. Opcode 0x1A subtracts one from it. The byte at the lower offset is the least significant byte.
- R3: Counting the start-accepting cycle as cycle 0, the bus runs in this order. Cycle 1 asserts `pc_req`. Cycle 2 reads `off`. Cycle 3 writes the new low byte to `off`. Cycle 4 reads `off+1`. Cycle 5 writes the new high byte to `off+1`. At most one of `pc_req`, `mem_rd` and `mem_wr` is high in any cycle.
- R4: When the low byte goes from 0xFF to 0x00, the high byte is incremented. When the low byte goes from 0x00 to 0xFF, the high byte is decremented.
- R5: The high-byte address is `off+1` modulo 256, so an offset of 0xFF puts the high byte at 0x00.
- R6: `flag_n` takes bit 15 of the 16-bit result and `flag_z` is 1 exactly when all 16 bits are zero. Both update at the clock edge that ends cycle 5 and hold their value at every other time.
- R7: `busy` is high in cycles 1 to 5. `done` is high for exactly one cycle, cycle 6, which is also the first cycle in which the new flags are visible.
- R8: A `start` while the unit is busy is ignored. A `start` with any opcode other than 0x3A or 0x1A is ignored: there is no bus activity and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled while idle |
| opcode | input | 8 | Operation select (0x3A add one, 0x1A subtract one) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final write |
| pc_req | output | 1 | Fetch of the offset byte from the instruction stream |
| pc_byte | input | 8 | Fetched offset byte, valid while `pc_req` is high |
| mem_addr | output | 8 | Direct-page byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| flag_n | output | 1 | Sign of the last 16-bit result |
| flag_z | output | 1 | Last 16-bit result was zero |

## Verification
A wrong carry or borrow in the accumulator shows up at the port in cycle 5, when `mem_wdata` carries the high byte. It also shows up one cycle later in the flags. A low byte adjusted the wrong way shows up two cycles earlier, on the cycle-3 write. A wrong offset register shows up on the address lines by cycle 2, or by cycle 4 for the wrap from 0xFF to 0x00. A sequencer that accepts a bad opcode or a second start shows up within one cycle as `busy` or a bus strobe. The bench therefore samples the bus in every cycle of each sequence, not only the final memory contents.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_OFS  = 3'd1,
        PH_RLO  = 3'd2,
        PH_WLO  = 3'd3,
        PH_RHI  = 3'd4,
        PH_WHI  = 3'd5
    } phase_e;

    localparam logic [7:0] OPC_WINC = 8'h3A;
    localparam logic [7:0] OPC_WDEC = 8'h1A;

    function automatic logic opc_known(input logic [7:0] opc);
        return (opc == OPC_WINC) || (opc == OPC_WDEC);
    endfunction

endpackage

// File: rtl/dpw_seq.sv
module dpw_seq
    import dpw_pkg::*;
(
    input  phase_e phase_q,
    input  logic   launch,
    output phase_e phase_d
);
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: phase_d = launch ? PH_OFS : PH_IDLE;
            PH_OFS:  phase_d = PH_RLO;
            PH_RLO:  phase_d = PH_WLO;
            PH_WLO:  phase_d = PH_RHI;
            PH_RHI:  phase_d = PH_WHI;
            PH_WHI:  phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/dpw_word_step.sv
module dpw_word_step
    import dpw_pkg::*;
#(
    parameter int DW = 8,
    localparam int WW = 2 * DW
) (
    input  phase_e          phase_q,
    input  logic            dec_q,
    input  logic [DW-1:0]   rdata,
    input  logic [WW-1:0]   acc_q,
    output logic [WW-1:0]   acc_d
);
    logic [WW-1:0] seed;
    logic [WW-1:0] delta;

    always_comb begin
        seed  = {{DW{1'b0}}, rdata};
        delta = dec_q ? {WW{1'b1}} : WW'(1);
        acc_d = acc_q;
        if (phase_q == PH_RLO) begin
            acc_d = seed + delta;
        end else if (phase_q == PH_RHI) begin
            acc_d = acc_q + {rdata, {DW{1'b0}}};
        end
    end
endmodule

// File: rtl/dpw_flag_eval.sv
module dpw_flag_eval #(
    parameter int WW = 16
) (
    input  logic [WW-1:0] word,
    output logic          neg,
    output logic          zero
);
    always_comb begin
        neg  = word[WW-1];
        zero = (word == '0);
    end
endmodule

// File: rtl/dpw_word_unit.sv
module dpw_word_unit
    import dpw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    output logic          busy,
    output logic          done,
    output logic          pc_req,
    input  logic [DW-1:0] pc_byte,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          flag_n,
    output logic          flag_z
);
    localparam int WW = 2 * DW;

    typedef struct packed {
        phase_e        phase;
        logic [DW-1:0] off;
        logic [WW-1:0] acc;
        logic          dec;
        logic          n;
        logic          z;
        logic          done;
    } unit_st_t;

    unit_st_t      s_d;
    unit_st_t      s_q;
    phase_e        phase_nx;
    logic [WW-1:0] acc_nx;
    logic          launch;
    logic          res_n;
    logic          res_z;

    assign launch = start && opc_known(opcode);

    dpw_seq u_seq (
        .phase_q (s_q.phase),
        .launch  (launch),
        .phase_d (phase_nx)
    );

    dpw_word_step #(.DW(DW)) u_step (
        .phase_q (s_q.phase),
        .dec_q   (s_q.dec),
        .rdata   (mem_rdata),
        .acc_q   (s_q.acc),
        .acc_d   (acc_nx)
    );

    dpw_flag_eval #(.WW(WW)) u_flags (
        .word (s_q.acc),
        .neg  (res_n),
        .zero (res_z)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = phase_nx;
        s_d.acc   = acc_nx;
        s_d.done  = 1'b0;
        pc_req    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = s_q.off;
        mem_wdata = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    s_d.dec = (opcode == OPC_WDEC);
                end
            end
            PH_OFS: begin
                pc_req  = 1'b1;
                s_d.off = pc_byte;
            end
            PH_RLO: begin
                mem_rd = 1'b1;
            end
            PH_WLO: begin
                mem_wr    = 1'b1;
                mem_wdata = s_q.acc[DW-1:0];
                s_d.off   = s_q.off + DW'(1);
            end
            PH_RHI: begin
                mem_rd = 1'b1;
            end
            PH_WHI: begin
                mem_wr    = 1'b1;
                mem_wdata = s_q.acc[WW-1:DW];
                s_d.n     = res_n;
                s_d.z     = res_z;
                s_d.done  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, off: '0, acc: '0, dec: 1'b0,
                     n: 1'b0, z: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.phase != PH_IDLE);
    assign done   = s_q.done;
    assign flag_n = s_q.n;
    assign flag_z = s_q.z;

endmodule

// File: rtl/dpw_word_unit_chk.sv
module dpw_word_unit_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [7:0]    opcode,
    input logic          busy,
    input logic          done,
    input logic          pc_req,
    input logic [DW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          flag_n,
    input logic          flag_z
);
    logic bad_launch;
    assign bad_launch = start && (opcode != 8'h3A) && (opcode != 8'h1A);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(pc_req || mem_rd || mem_wr));

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_req, mem_rd, mem_wr}) <= 1);

    p_lo_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_rd) && $past(pc_req, 2)) |-> (mem_addr == $past(mem_addr)));

    p_hi_next_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_wr)) |-> (mem_addr == DW'($past(mem_addr) + DW'(1))));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_wr) && !busy));

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(flag_n) && $stable(flag_z)));

    p_bad_opc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bad_launch) |=> !busy);

endmodule

bind dpw_word_unit dpw_word_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_dpw_word_unit.sv
module sim_dpw_word_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic       busy, done, pc_req, mem_rd, mem_wr, flag_n, flag_z;
    logic [7:0] pc_byte = 8'h00;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dpw_word_unit u0 (.clk, .rst_n, .start, .opcode, .busy, .done, .pc_req,
        .pc_byte, .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .mem_rdata,
        .flag_n, .flag_z);

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    // {opcode, offset, low byte, high byte}
    localparam logic [31:0] VEC [8] = '{
        32'h3A10_3412, 32'h3A20_FF12, 32'h1A30_0013, 32'h1A40_0100,
        32'h3A50_FFFF, 32'h1A60_0000, 32'h3A70_FF7F, 32'h3AFF_FF01
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // runs one sequence; hold keeps start high in cycles 1..4 (R8)
    task automatic run_op(input logic [7:0] opc, input logic [7:0] off,
                          input logic [7:0] lo, input logic [7:0] hi, input logic hold);
        logic [7:0]  offh;
        logic [15:0] res;
        logic        pn, pz;
        offh = off + 8'd1;
        res  = (opc == 8'h3A) ? {hi, lo} + 16'd1 : {hi, lo} - 16'd1;
        mem[off]  = lo;
        mem[offh] = hi;
        pn = flag_n; pz = flag_z;
        pc_byte = off; opcode = opc; start = 1'b1;
        @(negedge clk);
        start = hold;
        chk(pc_req && busy && !mem_rd && !mem_wr, "R3 R7 cycle1 fetch", {pc_req, busy}, 2'b11);
        @(negedge clk);
        chk(mem_rd && !mem_wr && mem_addr == off, "R3 cycle2 low read", mem_addr, off);
        @(negedge clk);
        chk(mem_wr && mem_addr == off && mem_wdata == res[7:0], "R2 R3 cycle3 low write",
            mem_wdata, res[7:0]);
        @(negedge clk);
        chk(mem_rd && mem_addr == offh, "R3 R5 cycle4 high read", mem_addr, offh);
        chk(!done && flag_n == pn && flag_z == pz, "R6 flags held mid-op", {flag_n, flag_z}, {pn, pz});
        @(negedge clk);
        start = 1'b0;
        chk(mem_wr && busy && mem_addr == offh && mem_wdata == res[15:8], "R2 R4 cycle5 high write",
            mem_wdata, res[15:8]);
        @(negedge clk);
        chk(done && !busy, "R7 done pulse", {done, busy}, 2'b10);
        chk(flag_n == res[15] && flag_z == (res == 16'd0), "R6 flags", {flag_n, flag_z},
            {res[15], res == 16'd0});
        chk({mem[offh], mem[off]} == res, "R2 R4 R5 stored word", {mem[offh], mem[off]}, res);
        @(negedge clk);
        chk(!done && !busy, "R7 R8 single pass", {done, busy}, 2'b00);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pc_req && !mem_rd && !mem_wr && !flag_n && !flag_z,
            "R1 reset state", {busy, done, pc_req, mem_rd, mem_wr, flag_n, flag_z}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !pc_req && !mem_rd && !mem_wr, "R1 idle after reset", busy, 0);

        for (int v = 0; v < 8; v++) begin
            run_op(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R8: bad opcode is ignored, flags (Z=1 from last op? check whatever stands) held
        begin
            logic pn, pz;
            run_op(8'h1A, 8'h80, 8'h01, 8'h00, 1'b0);   // result zero
            pn = flag_n; pz = flag_z;
            chk(pz && !pn, "R6 zero result", {pn, pz}, 2'b01);
            opcode = 8'h55; start = 1'b1; pc_byte = 8'h80;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                chk(!busy && !pc_req && !mem_rd && !mem_wr, "R8 bad opcode ignored",
                    {busy, pc_req, mem_rd, mem_wr}, 0);
            end
            start = 1'b0;
            chk(flag_n == pn && flag_z == pz && mem[8'h80] == 8'h00, "R6 R8 state kept",
                {flag_n, flag_z}, {pn, pz});
        end

        // R8: start held high during the sequence is ignored
        run_op(8'h3A, 8'h90, 8'hFF, 8'h00, 1'b1);
        run_op(8'h1A, 8'hFF, 8'h00, 8'h00, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule